// File: doc/BRIEF.md
# Multi-mode AIS and Idle Detector

This block sits behind a DS3 or E3 framer. It examines the received stream one bit per enabled clock. The framer supplies four things: a tag that classifies each bit, a marker on the last bit of each frame, an out-of-frame flag, and a flag that says the frame's overhead was valid. For each frame the block counts how far that frame strays from the alarm pattern that applies. In DS3 it counts deviations from the alarm-indication pattern and from the idle pattern. In the two E3 modes it counts received zeros. It then declares or clears an alarm only after two back-to-back frames agree.

Each alarm gives a level status output, a one-cycle start pulse when it is declared and a one-cycle end pulse when it clears. The auto-all-ones enable substitutes ones for the outgoing data while any alarm is active. Framing and overhead validation stay with the framer.

Top module: `alarm_sig_detector`

## Requirements
- R1: In DS3 (mode_i=0), AIS is declared after two consecutive frames that each have at most 10 deviations, ovh_ok_i high and oof_i low. The frame is judged at the bit carrying frame_end_i. A deviation is one of the following:
  - a payload bit (kind 0) that differs from 1 at even payload index and from 0 at odd index;
  - a C-bit (kind 1 or 2) that is 1;
  - an X-bit (kind 3) that is 0.
  Bits of kind 4 to 7 are not counted.
- R2: In DS3, AIS and IDLE clear on the clock after oof_i is seen high, whatever the frame position. AIS also clears after two consecutive frames that each have 11 or more deviations.
- R3: In DS3, IDLE follows the same thresholds and qualification as R1. The expected payload is 1 at payload index mod 4 of 0 or 1, and 0 at 2 or 3. Kind 2 bits must be 0 and kind 3 bits must be 1. Kind 1 bits are ignored.
- R4: In G.751 mode (mode_i=1), AIS is declared after two consecutive frames with at most 4 zeros each, counted over all bits. It clears after two consecutive frames with 5 or more zeros each.
- R5: In G.832 mode (mode_i=2, and also 3), AIS is declared after two consecutive frames with at most 9 zeros each. It clears after two consecutive frames with 10 or more zeros each.
- R6: In either E3 mode, while oof_i is low, a frame whose alignment bits (kind 5) hold more than 2 zeros does not count toward declaring AIS. While oof_i is high the alignment-bit count is ignored. IDLE never becomes active outside DS3.
- R7: After reset, all outputs except data_o are low. Status changes on the clock after the frame-end bit. Each declaration gives exactly one one-cycle start pulse and each clearing exactly one one-cycle end pulse, in the first cycle of the new status.
- R8: data_o equals data_i, except that it is 1 while auto_ones_i is high and AIS or IDLE is active.
- R9: A frame that fails the pending test resets the consecutive count, so the two qualifying frames must be adjacent.
- R10: The payload index restarts at 0 after every frame end and advances only on enabled payload bits. Cycles with bit_vld_i low change no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 DS3, 1 E3 G.751, 2 or 3 E3 G.832 |
| bit_vld_i | input | 1 | Current data_i bit is a received bit |
| data_i | input | 1 | Received bit |
| kind_i | input | 3 | Bit class: 0 payload, 1 C-bit, 2 C-bit of subframe 3, 3 X-bit, 4 F/M/P, 5 alignment |
| frame_end_i | input | 1 | Current bit is the last of its frame |
| ovh_ok_i | input | 1 | F, M and P bits of this frame were valid (DS3) |
| oof_i | input | 1 | Framer is out of frame |
| auto_ones_i | input | 1 | Force data_o to ones while an alarm is active |
| data_o | output | 1 | Received data, possibly forced to ones |
| ais_o | output | 1 | AIS status |
| idle_o | output | 1 | IDLE status |
| ais_start_o | output | 1 | One-cycle pulse on AIS declaration |
| ais_end_o | output | 1 | One-cycle pulse on AIS clearing |
| idle_start_o | output | 1 | One-cycle pulse on IDLE declaration |
| idle_end_o | output | 1 | One-cycle pulse on IDLE clearing |

## Verification
The bench builds the block with its default thresholds: 10 deviations for DS3, 4 and 9 zeros for the E3 modes, 2 alignment zeros and a two-frame rule. It uses 13-bit counters and a 48-bit frame. A 48-bit frame holds 42 payload bits, which is enough for the exact limit frames at 10 versus 11 deviations, 4 versus 5 zeros and 9 versus 10 zeros. Random gap cycles inside frames test that the payload phase follows only enabled bits. Short frames also let hundreds of random declare and clear sequences run in each mode.

// File: rtl/asd_pkg.sv
package asd_pkg;

  typedef enum logic [1:0] {
    MODE_DS3  = 2'd0,
    MODE_G751 = 2'd1,
    MODE_G832 = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    K_PAY  = 3'd0,
    K_CBIT = 3'd1,
    K_CB3  = 3'd2,
    K_XBIT = 3'd3,
    K_FMP  = 3'd4,
    K_FAS  = 3'd5
  } kind_e;

  // deviation from the alternating alarm pattern, given the payload phase
  function automatic logic ais_miss(input logic [2:0] kind, input logic [1:0] ph, input logic d);
    case (kind)
      K_PAY:         return d == ph[0];
      K_CBIT, K_CB3: return d;
      K_XBIT:        return !d;
      default:       return 1'b0;
    endcase
  endfunction

  // deviation from the 1100 idle pattern
  function automatic logic idle_miss(input logic [2:0] kind, input logic [1:0] ph, input logic d);
    case (kind)
      K_PAY:   return d == ph[1];
      K_CB3:   return d;
      K_XBIT:  return !d;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/asd_frame_acc.sv
module asd_frame_acc
  import asd_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld_i,
  input  logic             frame_end_i,
  input  logic             data_i,
  input  logic [2:0]       kind_i,
  output logic [CNT_W-1:0] ais_dev_o,
  output logic [CNT_W-1:0] idle_dev_o,
  output logic [CNT_W-1:0] zero_o,
  output logic [CNT_W-1:0] fas_zero_o
);
  localparam int NACC = 4;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v, input logic inc);
    return (inc && v != CMAX) ? v + 1'b1 : v;
  endfunction

  logic [1:0]       phase_q;
  logic [NACC-1:0]  hit;
  logic [CNT_W-1:0] acc_q [NACC];
  logic [CNT_W-1:0] tot   [NACC];

  assign hit[0] = ais_miss(kind_i, phase_q, data_i);
  assign hit[1] = idle_miss(kind_i, phase_q, data_i);
  assign hit[2] = !data_i;
  assign hit[3] = !data_i && (kind_i == K_FAS);

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    assign tot[g] = sat_inc(acc_q[g], hit[g] & bit_vld_i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       acc_q[g] <= '0;
      else if (bit_vld_i && frame_end_i) acc_q[g] <= '0;
      else if (bit_vld_i)                acc_q[g] <= tot[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        phase_q <= '0;
    else if (bit_vld_i && frame_end_i) phase_q <= '0;
    else if (bit_vld_i && kind_i == K_PAY) phase_q <= phase_q + 2'd1;
  end

  assign ais_dev_o  = tot[0];
  assign idle_dev_o = tot[1];
  assign zero_o     = tot[2];
  assign fas_zero_o = tot[3];
endmodule

// File: rtl/asd_alarm_fsm.sv
module asd_alarm_fsm #(
  parameter int CONSEC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eval_i,
  input  logic qual_set_i,
  input  logic qual_clr_i,
  input  logic force_clr_i,
  output logic active_o,
  output logic start_o,
  output logic end_o
);
  localparam int CW = (CONSEC > 1) ? $clog2(CONSEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONSEC - 1);

  logic [CW-1:0] run_q;
  logic          toward;

  assign toward = active_o ? qual_clr_i : qual_set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      run_q    <= '0;
      start_o  <= 1'b0;
      end_o    <= 1'b0;
    end else begin
      start_o <= 1'b0;
      end_o   <= 1'b0;
      if (force_clr_i) begin
        run_q <= '0;
        if (active_o) begin
          active_o <= 1'b0;
          end_o    <= 1'b1;
        end
      end else if (eval_i) begin
        if (!toward) begin
          run_q <= '0;
        end else if (run_q == LAST) begin
          run_q    <= '0;
          active_o <= !active_o;
          start_o  <= !active_o;
          end_o    <= active_o;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/alarm_sig_detector.sv
module alarm_sig_detector
  import asd_pkg::*;
#(
  parameter int CNT_W         = 13,
  parameter int DS3_DEV_MAX   = 10,
  parameter int G751_ZERO_MAX = 4,
  parameter int G832_ZERO_MAX = 9,
  parameter int FAS_ZERO_MAX  = 2,
  parameter int CONSEC_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       bit_vld_i,
  input  logic       data_i,
  input  logic [2:0] kind_i,
  input  logic       frame_end_i,
  input  logic       ovh_ok_i,
  input  logic       oof_i,
  input  logic       auto_ones_i,
  output logic       data_o,
  output logic       ais_o,
  output logic       idle_o,
  output logic       ais_start_o,
  output logic       ais_end_o,
  output logic       idle_start_o,
  output logic       idle_end_o
);
  localparam logic [CNT_W-1:0] DEV_LIM = CNT_W'(DS3_DEV_MAX);
  localparam logic [CNT_W-1:0] FAS_LIM = CNT_W'(FAS_ZERO_MAX);

  function automatic logic [CNT_W-1:0] zero_limit(input logic [1:0] m);
    return (m == MODE_G751) ? CNT_W'(G751_ZERO_MAX) : CNT_W'(G832_ZERO_MAX);
  endfunction

  logic [CNT_W-1:0] ais_dev, idle_dev, zero_cnt, fas_zero;
  logic frame_eval, is_ds3;
  logic ais_set_q, ais_clr_q, idle_set_q, idle_clr_q;
  logic ais_force, idle_force;

  asd_frame_acc #(.CNT_W(CNT_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld_i), .frame_end_i(frame_end_i),
    .data_i(data_i), .kind_i(kind_i),
    .ais_dev_o(ais_dev), .idle_dev_o(idle_dev), .zero_o(zero_cnt), .fas_zero_o(fas_zero)
  );

  assign frame_eval = bit_vld_i && frame_end_i;
  assign is_ds3     = (mode_i == MODE_DS3);

  assign ais_set_q = is_ds3
    ? (ais_dev <= DEV_LIM && ovh_ok_i && !oof_i)
    : (zero_cnt <= zero_limit(mode_i) && (oof_i || fas_zero <= FAS_LIM));
  assign ais_clr_q = is_ds3 ? (ais_dev > DEV_LIM) : (zero_cnt > zero_limit(mode_i));

  assign idle_set_q = (idle_dev <= DEV_LIM) && ovh_ok_i && !oof_i;
  assign idle_clr_q = (idle_dev > DEV_LIM);

  assign ais_force  = is_ds3 && oof_i;
  assign idle_force = !is_ds3 || oof_i;

  asd_alarm_fsm #(.CONSEC(CONSEC_FRAMES)) ais_fsm_i (
    .clk(clk), .rst_n(rst_n), .eval_i(frame_eval),
    .qual_set_i(ais_set_q), .qual_clr_i(ais_clr_q), .force_clr_i(ais_force),
    .active_o(ais_o), .start_o(ais_start_o), .end_o(ais_end_o)
  );

  asd_alarm_fsm #(.CONSEC(CONSEC_FRAMES)) idle_fsm_i (
    .clk(clk), .rst_n(rst_n), .eval_i(frame_eval),
    .qual_set_i(idle_set_q), .qual_clr_i(idle_clr_q), .force_clr_i(idle_force),
    .active_o(idle_o), .start_o(idle_start_o), .end_o(idle_end_o)
  );

  assign data_o = data_i | (auto_ones_i & (ais_o | idle_o));
endmodule

// File: rtl/asd_checker.sv
module asd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       oof_i,
  input logic       frame_eval,
  input logic       ais_o,
  input logic       idle_o,
  input logic       ais_start_o,
  input logic       ais_end_o,
  input logic       idle_start_o
);
  p_start_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ais_start_o |-> (ais_o && !$past(ais_o)));

  p_end_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ais_end_o |-> (!ais_o && $past(ais_o)));

  p_idle_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_start_o |-> (idle_o && $past(frame_eval)));

  p_rise_on_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ais_o) |-> $past(frame_eval));

  p_oof_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 && oof_i) |=> (!ais_o && !idle_o));

  p_idle_ds3_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'd0) |=> !idle_o);
endmodule

bind alarm_sig_detector asd_checker chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .oof_i(oof_i), .frame_eval(frame_eval),
  .ais_o(ais_o), .idle_o(idle_o), .ais_start_o(ais_start_o), .ais_end_o(ais_end_o),
  .idle_start_o(idle_start_o)
);

// File: tb/alarm_sig_detector_tb_top.sv
`timescale 1ns/1ps
module alarm_sig_detector_tb_top;
  localparam int FL = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic vld = 1'b0, din = 1'b0, fend = 1'b0, ovh = 1'b1, oof = 1'b0, auto1 = 1'b0;
  logic [2:0] kind = 3'd0;
  logic dout, ais, idle, ais_s, ais_e, idle_s, idle_e;

  int checks = 0, errors = 0;
  bit e_ais, e_idle;
  int c_ais, c_idle;

  always #2.5 clk = ~clk;

  alarm_sig_detector dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .bit_vld_i(vld), .data_i(din), .kind_i(kind),
    .frame_end_i(fend), .ovh_ok_i(ovh), .oof_i(oof), .auto_ones_i(auto1),
    .data_o(dout), .ais_o(ais), .idle_o(idle), .ais_start_o(ais_s), .ais_end_o(ais_e),
    .idle_start_o(idle_s), .idle_end_o(idle_e)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // bench frame layout: every 8th bit is overhead cycling F/M/P, C, C3, X; E3 alignment in bits 0..3
  function automatic logic [2:0] kind_of(input int p, input logic [1:0] m);
    if (m != 2'd0) return (p < 4) ? 3'd5 : 3'd0;
    if (p % 8 != 0) return 3'd0;
    case ((p / 8) % 4)
      0: return 3'd4;
      1: return 3'd1;
      2: return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

  // expected bit for target 0 (AIS) or 1 (IDLE); second return: whether it is judged
  function automatic bit want(input int tgt, input logic [2:0] k, input int pidx, output bit judged);
    judged = 1'b1;
    case (k)
      3'd0: return (tgt == 0) ? ((pidx % 2) == 0) : ((pidx % 4) < 2);
      3'd1: begin judged = (tgt == 0); return 1'b0; end
      3'd2: return 1'b0;
      3'd3: return 1'b1;
      default: begin judged = 1'b0; return 1'b1; end
    endcase
  endfunction

  function automatic int ref_dev(input int tgt, input logic [FL-1:0] b);
    int n = 0, pidx = 0;
    for (int p = 0; p < FL; p++) begin
      bit j, w;
      logic [2:0] k = kind_of(p, 2'd0);
      w = want(tgt, k, pidx, j);
      if (j && b[p] != w) n++;
      if (k == 3'd0) pidx++;
    end
    return n;
  endfunction

  function automatic logic [FL-1:0] make_ds3(input int tgt, input int ndev);
    logic [FL-1:0] b;
    int pidx = 0, left = ndev;
    for (int p = 0; p < FL; p++) begin
      bit j;
      logic [2:0] k = kind_of(p, 2'd0);
      b[p] = want(tgt, k, pidx, j);
      if (k == 3'd0) begin
        if (left > 0) begin b[p] = ~b[p]; left--; end
        pidx++;
      end
    end
    return b;
  endfunction

  function automatic logic [FL-1:0] make_e3(input int nz, input int nfas);
    logic [FL-1:0] b = '1;
    for (int p = 0; p < nfas; p++) b[p] = 1'b0;
    for (int p = 4; p < 4 + (nz - nfas); p++) b[p] = 1'b0;
    return b;
  endfunction

  task automatic upd(inout bit act, inout int cnt, input bit qs, input bit qc,
                     inout int st, inout int en);
    bit q = act ? qc : qs;
    if (!q) cnt = 0;
    else if (cnt + 1 >= 2) begin
      cnt = 0;
      if (act) en++; else st++;
      act = !act;
    end else cnt++;
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode = m; vld = 1'b0; fend = 1'b0; oof = 1'b0; auto1 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e_ais = 0; e_idle = 0; c_ais = 0; c_idle = 0;
    @(negedge clk);
    chk(ais == 0 && idle == 0 && ais_s == 0 && ais_e == 0 && idle_s == 0 && idle_e == 0,
        "R7 reset", {ais, idle, ais_s, ais_e, idle_s, idle_e}, 0);
  endtask

  task automatic run_frame(input logic [FL-1:0] b, input bit f_oof, input bit f_ovh, input bit gaps);
    int sa = 0, ea = 0, si = 0, ei = 0;
    int xsa = 0, xea = 0, xsi = 0, xei = 0;
    string tag;
    for (int p = 0; p < FL; p++) begin
      if (gaps && ($urandom % 8) == 0) begin
        @(negedge clk);
        sa += ais_s; ea += ais_e; si += idle_s; ei += idle_e;
        vld = 1'b0; din = 1'($urandom); kind = 3'($urandom); fend = ($urandom % 2) == 0;
      end
      @(negedge clk);
      sa += ais_s; ea += ais_e; si += idle_s; ei += idle_e;
      vld = 1'b1; din = b[p]; kind = kind_of(p, mode); fend = (p == FL - 1);
      oof = f_oof; ovh = f_ovh;
    end
    @(negedge clk);
    sa += ais_s; ea += ais_e; si += idle_s; ei += idle_e;
    vld = 1'b0; fend = 1'b0;
    if (mode == 2'd0) begin
      int da = ref_dev(0, b), di = ref_dev(1, b);
      if (f_oof) begin
        if (e_ais) xea++;
        if (e_idle) xei++;
        e_ais = 0; e_idle = 0; c_ais = 0; c_idle = 0;
      end else begin
        upd(e_ais, c_ais, da <= 10 && f_ovh, da >= 11, xsa, xea);
        upd(e_idle, c_idle, di <= 10 && f_ovh, di >= 11, xsi, xei);
      end
      tag = "R1";
    end else begin
      int z = 0, fz = 0, lim = (mode == 2'd1) ? 4 : 9;
      for (int p = 0; p < FL; p++) if (!b[p]) begin z++; if (p < 4) fz++; end
      upd(e_ais, c_ais, z <= lim && (f_oof || fz <= 2), z > lim, xsa, xea);
      tag = (mode == 2'd1) ? "R4" : "R5";
    end
    chk(ais == e_ais, tag, ais, e_ais);
    chk(idle == e_idle, "R3 idle", idle, e_idle);
    chk(sa == xsa && ea == xea, "R7 ais pulses", sa * 10 + ea, xsa * 10 + xea);
    chk(si == xsi && ei == xei, "R7 idle pulses", si * 10 + ei, xsi * 10 + xei);
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));

    // ---- DS3 directed ----
    do_reset(2'd0);
    run_frame(make_ds3(0, 10), 0, 1, 0);
    chk(ais == 0, "R1 one frame only", ais, 0);
    run_frame(make_ds3(0, 10), 0, 1, 0);
    chk(ais == 1, "R1 two frames at limit", ais, 1);
    run_frame(make_ds3(0, 11), 0, 1, 0);
    run_frame(make_ds3(0, 0), 0, 1, 0);
    run_frame(make_ds3(0, 11), 0, 1, 0);
    chk(ais == 1, "R9 clear frames not adjacent", ais, 1);
    run_frame(make_ds3(0, 11), 0, 1, 0);
    chk(ais == 0, "R2 two frames over limit", ais, 0);
    run_frame(make_ds3(0, 0), 0, 1, 0);
    run_frame(make_ds3(0, 0), 0, 0, 0);
    chk(ais == 0, "R1 bad overhead blocks", ais, 0);
    run_frame(make_ds3(0, 0), 0, 1, 0);
    run_frame(make_ds3(0, 0), 0, 1, 0);
    run_frame(make_ds3(0, 0), 1, 1, 0);
    chk(ais == 0, "R2 out of frame clears", ais, 0);
    run_frame(make_ds3(1, 10), 0, 1, 0);
    run_frame(make_ds3(1, 10), 0, 1, 0);
    chk(idle == 1 && ais == 0, "R3 idle declared", {idle, ais}, 2);
    @(negedge clk);
    din = 1'b0; auto1 = 1'b1; #1;
    chk(dout == 1, "R8 forced ones", dout, 1);
    auto1 = 1'b0; #1;
    chk(dout == 0, "R8 passthrough", dout, 0);
    do_reset(2'd0);
    run_frame(make_ds3(0, 0), 0, 1, 1);
    run_frame(make_ds3(0, 3), 0, 1, 1);
    chk(ais == 1, "R10 gaps keep phase", ais, 1);
    @(negedge clk);
    din = 1'b0; auto1 = 1'b1; #1;
    chk(dout == 1, "R8 forced ones on AIS", dout, 1);
    auto1 = 1'b0;

    // ---- DS3 random ----
    do_reset(2'd0);
    for (int f = 0; f < 160; f++) begin
      int tgt = $urandom % 3;
      logic [FL-1:0] b = (tgt == 2) ? {$urandom, $urandom} : make_ds3(tgt, 0);
      int nf = $urandom % 16;
      for (int i = 0; i < nf; i++) b[$urandom % FL] ^= 1'b1;
      run_frame(b, ($urandom % 16) == 0, ($urandom % 8) != 0, ($urandom % 4) == 0);
    end

    // ---- G.751 directed and random ----
    do_reset(2'd1);
    run_frame(make_e3(4, 0), 0, 1, 0);
    run_frame(make_e3(4, 2), 1, 0, 0);
    chk(ais == 1, "R4 four zeros twice", ais, 1);
    run_frame(make_e3(5, 0), 0, 1, 0);
    run_frame(make_e3(5, 0), 0, 1, 0);
    chk(ais == 0, "R4 five zeros twice", ais, 0);
    run_frame(make_e3(3, 3), 0, 1, 0);
    run_frame(make_e3(3, 3), 0, 1, 0);
    chk(ais == 0, "R6 framed all-ones rejected", ais, 0);
    run_frame(make_e3(3, 3), 1, 1, 0);
    run_frame(make_e3(3, 3), 1, 1, 0);
    chk(ais == 1 && idle == 0, "R6 alignment ignored out of frame", {ais, idle}, 2);
    for (int f = 0; f < 150; f++) begin
      logic [FL-1:0] b = '1;
      int nz = $urandom % 9;
      for (int i = 0; i < nz; i++) b[$urandom % FL] = 1'b0;
      run_frame(b, ($urandom % 4) == 0, 1'($urandom), ($urandom % 4) == 0);
    end

    // ---- G.832 directed and random ----
    do_reset(2'd2);
    run_frame(make_e3(9, 2), 0, 1, 0);
    run_frame(make_e3(9, 0), 0, 1, 0);
    chk(ais == 1, "R5 nine zeros twice", ais, 1);
    run_frame(make_e3(10, 0), 0, 1, 0);
    run_frame(make_e3(10, 0), 0, 1, 0);
    chk(ais == 0, "R5 ten zeros twice", ais, 0);
    for (int f = 0; f < 150; f++) begin
      logic [FL-1:0] b = '1;
      int nz = $urandom % 16;
      for (int i = 0; i < nz; i++) b[$urandom % FL] = 1'b0;
      run_frame(b, ($urandom % 4) == 0, 1'($urandom), ($urandom % 4) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule